// File: doc/BRIEF.md
# Multi-Port GPIO Register Bank with APB Access

This block is the register front end of a general-purpose I/O peripheral on an APB slave port. It holds up to four ports of pins. Each port has a writable output-value register and a writable drive-enable register. Each port also has a read-only view of its pin levels, taken through a two-flop synchronizer. The output-value and drive-enable registers feed the pad outputs and pad output enables directly. The pin-level view lets software see the pads whether or not they are driven.

Interrupt detection lives in a separate block. This bank only recognises the seven interrupt-related offsets and routes them. For each such access it gives a one-hot register select, a write strobe and the write data. On a read it returns the data that the interrupt block supplies. A build parameter chooses between two offset layouts for those interrupt registers. Every transfer completes in one access cycle with no error response.

Top module: `apb_gpio_bank`

## Requirements
- R1: After reset every output-value and drive-enable bit is 0, so every pad output and every pad output enable is 0.
- R2: The output-value register of port n is at byte offset 12·n. A write takes effect on the clock edge that ends the access phase. From then on the register reads back the written value and drives that port's slice of `pad_o`.
- R3: The drive-enable register of port n is at byte offset 12·n + 4. It reads back the written value, and bit i drives `pad_oe_o` bit i of that port (1 = pin driven, 0 = input).
- R4: A read at offset 0x50 + 4·n returns port n's pad inputs as they were sampled two rising edges earlier. Writes to these offsets change nothing.
- R5: Each port has a width parameter of 1 to 32 bits. Register bits at or above that width read as 0, ignore writes, and hold their pad output, output enable and pin-level read at 0.
- R6: In the default layout the interrupt offsets are 0x30, 0x34, 0x38, 0x3C, 0x40, 0x48 and 0x4C. They map in that order to `irq_sel_o` bits 0 to 6: enable, mask, type, polarity, status, debounce and end-of-interrupt. An access asserts exactly that select bit, a write also asserts `irq_we_o`, and a read returns `irq_rdata_i`.
- R7: With the alternate layout selected, the offsets become: mask 0x44, type 0x34, polarity 0x38, status 0x3C, end-of-interrupt 0x40. Enable stays at 0x30 and debounce stays at 0x48. The select bit order is the same as in R6.
- R8: Any other offset, including those of ports beyond the configured count and offsets that are not word aligned, reads as 0 and ignores writes.
- R9: `pready_o` is always 1 and `pslverr_o` is always 0.
- R10: Only the access phase (select and enable both high) writes a register or raises `irq_sel_o` or `irq_we_o`. A setup phase alone has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk_i | input | 1 | Bus and register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable (access phase) |
| pwrite_i | input | 1 | APB write when 1, read when 0 |
| paddr_i | input | ADDR_W | APB byte address |
| pwdata_i | input | 32 | APB write data |
| prdata_o | output | 32 | APB read data |
| pready_o | output | 1 | Always 1 |
| pslverr_o | output | 1 | Always 0 |
| pad_i | input | NUM_PORTS·32 | Pad input levels, port n in bits [32n+31:32n] |
| pad_o | output | NUM_PORTS·32 | Pad output values |
| pad_oe_o | output | NUM_PORTS·32 | Pad output enables |
| irq_sel_o | output | 7 | One-hot interrupt register select during an access |
| irq_we_o | output | 1 | Write strobe to the interrupt block |
| irq_wdata_o | output | 32 | Write data to the interrupt block |
| irq_rdata_i | input | 32 | Read data from the interrupt block |

## Verification
The bench puts a default-layout and an alternate-layout instance on the same bus. Both use narrow ports and fewer ports than the maximum. This makes sure that a decoder with the wrong offset table, one that lets a missing port alias onto a real one, or one that skips width masking gives a wrong read or a wrong select. Pad inputs change every cycle, so a synchronizer that is one stage too short or too long returns the wrong sample. Writes aimed at the pin-level offsets and setup phases that never reach the access phase would show up as changed pad outputs if the block wrote on them. Unaligned and unused offsets are read to catch any partial-address decode.

// File: rtl/apb_gpio_pkg.sv
package apb_gpio_pkg;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned MAX_PORTS  = 4;
  localparam int unsigned N_IRQ_REGS = 7;
  localparam int unsigned PORT_STRIDE = 12;
  localparam int unsigned EXT_BASE    = 'h50;
  localparam int unsigned EXT_STRIDE  = 4;

  typedef enum logic [2:0] {
    IRQ_ENABLE = 3'd0,
    IRQ_MASK   = 3'd1,
    IRQ_TYPE   = 3'd2,
    IRQ_POL    = 3'd3,
    IRQ_STATUS = 3'd4,
    IRQ_DEBNC  = 3'd5,
    IRQ_EOI    = 3'd6
  } irq_reg_e;

  function automatic logic [7:0] irq_offset(input int unsigned idx, input bit alt);
    case (idx)
      0:       return 8'h30;
      1:       return alt ? 8'h44 : 8'h34;
      2:       return alt ? 8'h34 : 8'h38;
      3:       return alt ? 8'h38 : 8'h3C;
      4:       return alt ? 8'h3C : 8'h40;
      5:       return 8'h48;
      default: return alt ? 8'h40 : 8'h4C;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] port_mask(input int unsigned w);
    if (w >= DATA_W) return '1;
    return (DATA_W'(1) << w) - DATA_W'(1);
  endfunction
endpackage

// File: rtl/apb_gpio_dec.sv
module apb_gpio_dec
  import apb_gpio_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned ADDR_W    = 8,
  parameter bit          ALT_MAP   = 1'b0
) (
  input  logic [ADDR_W-1:0]     addr_i,
  output logic [NUM_PORTS-1:0]  dr_hit_o,
  output logic [NUM_PORTS-1:0]  ddr_hit_o,
  output logic [NUM_PORTS-1:0]  ext_hit_o,
  output logic [N_IRQ_REGS-1:0] irq_hit_o
);
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign dr_hit_o[p]  = (addr_i == ADDR_W'(PORT_STRIDE * p));
    assign ddr_hit_o[p] = (addr_i == ADDR_W'(PORT_STRIDE * p + 4));
    assign ext_hit_o[p] = (addr_i == ADDR_W'(EXT_BASE + EXT_STRIDE * p));
  end

  for (genvar r = 0; r < N_IRQ_REGS; r++) begin : g_irq
    assign irq_hit_o[r] = (addr_i == ADDR_W'(irq_offset(r, ALT_MAP)));
  end
endmodule

// File: rtl/apb_gpio_port.sv
module apb_gpio_port
  import apb_gpio_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              dr_we_i,
  input  logic              ddr_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] pad_i,
  output logic [DATA_W-1:0] dr_o,
  output logic [DATA_W-1:0] ddr_o,
  output logic [DATA_W-1:0] ext_o
);
  localparam logic [DATA_W-1:0] MASK = port_mask(WIDTH);

  logic [DATA_W-1:0] dr_q, ddr_q, sync1_q, sync2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dr_q  <= '0;
      ddr_q <= '0;
    end else begin
      if (dr_we_i)  dr_q  <= wdata_i & MASK;
      if (ddr_we_i) ddr_q <= wdata_i & MASK;
    end
  end

  // two-stage synchronizer on the pin-level path
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pad_i & MASK;
      sync2_q <= sync1_q;
    end
  end

  assign dr_o  = dr_q;
  assign ddr_o = ddr_q;
  assign ext_o = sync2_q;
endmodule

// File: rtl/apb_gpio_bank.sv
module apb_gpio_bank
  import apb_gpio_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned PORT_W [MAX_PORTS] = '{32, 32, 32, 32},
  parameter int unsigned ADDR_W    = 8,
  parameter bit          ALT_MAP   = 1'b0,
  localparam int unsigned PAD_W    = NUM_PORTS * DATA_W
) (
  input  logic                  pclk_i,
  input  logic                  rst_ni,
  input  logic                  psel_i,
  input  logic                  penable_i,
  input  logic                  pwrite_i,
  input  logic [ADDR_W-1:0]     paddr_i,
  input  logic [DATA_W-1:0]     pwdata_i,
  output logic [DATA_W-1:0]     prdata_o,
  output logic                  pready_o,
  output logic                  pslverr_o,
  input  logic [PAD_W-1:0]      pad_i,
  output logic [PAD_W-1:0]      pad_o,
  output logic [PAD_W-1:0]      pad_oe_o,
  output logic [N_IRQ_REGS-1:0] irq_sel_o,
  output logic                  irq_we_o,
  output logic [DATA_W-1:0]     irq_wdata_o,
  input  logic [DATA_W-1:0]     irq_rdata_i
);
  logic access, wr_access, rd_access;
  logic [NUM_PORTS-1:0]  dr_hit, ddr_hit, ext_hit;
  logic [N_IRQ_REGS-1:0] irq_hit;
  logic [DATA_W-1:0] dr_q  [NUM_PORTS];
  logic [DATA_W-1:0] ddr_q [NUM_PORTS];
  logic [DATA_W-1:0] ext_q [NUM_PORTS];
  logic [DATA_W-1:0] rdata;

  assign access    = psel_i & penable_i;
  assign wr_access = access & pwrite_i;
  assign rd_access = access & ~pwrite_i;

  apb_gpio_dec #(
    .NUM_PORTS(NUM_PORTS),
    .ADDR_W   (ADDR_W),
    .ALT_MAP  (ALT_MAP)
  ) u_dec (
    .addr_i   (paddr_i),
    .dr_hit_o (dr_hit),
    .ddr_hit_o(ddr_hit),
    .ext_hit_o(ext_hit),
    .irq_hit_o(irq_hit)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    apb_gpio_port #(.WIDTH(PORT_W[p])) u_port (
      .clk_i   (pclk_i),
      .rst_ni  (rst_ni),
      .dr_we_i (wr_access & dr_hit[p]),
      .ddr_we_i(wr_access & ddr_hit[p]),
      .wdata_i (pwdata_i),
      .pad_i   (pad_i[p*DATA_W +: DATA_W]),
      .dr_o    (dr_q[p]),
      .ddr_o   (ddr_q[p]),
      .ext_o   (ext_q[p])
    );
    assign pad_o[p*DATA_W +: DATA_W]    = dr_q[p];
    assign pad_oe_o[p*DATA_W +: DATA_W] = ddr_q[p];
  end

  // hits are mutually exclusive, so an OR-mux suffices
  always_comb begin
    rdata = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (dr_hit[p])  rdata = rdata | dr_q[p];
      if (ddr_hit[p]) rdata = rdata | ddr_q[p];
      if (ext_hit[p]) rdata = rdata | ext_q[p];
    end
    if (|irq_hit) rdata = rdata | irq_rdata_i;
  end

  assign prdata_o    = rd_access ? rdata : '0;
  assign pready_o    = 1'b1;
  assign pslverr_o   = 1'b0;
  assign irq_sel_o   = access ? irq_hit : '0;
  assign irq_we_o    = wr_access & (|irq_hit);
  assign irq_wdata_o = pwdata_i;
endmodule

// File: rtl/apb_gpio_bank_chk.sv
module apb_gpio_bank_chk
  import apb_gpio_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned PORT_W [MAX_PORTS] = '{32, 32, 32, 32},
  localparam int unsigned PAD_W = NUM_PORTS * DATA_W
) (
  input logic                  pclk_i,
  input logic                  rst_ni,
  input logic                  psel_i,
  input logic                  penable_i,
  input logic                  pwrite_i,
  input logic                  pready_o,
  input logic                  pslverr_o,
  input logic [PAD_W-1:0]      pad_o,
  input logic [PAD_W-1:0]      pad_oe_o,
  input logic [N_IRQ_REGS-1:0] irq_sel_o,
  input logic                  irq_we_o
);
  a_r9_ready_no_error: assert property (@(posedge pclk_i) disable iff (!rst_ni)
    pready_o && !pslverr_o);

  a_r10_quiet_outside_access: assert property (@(posedge pclk_i) disable iff (!rst_ni)
    !(psel_i && penable_i) |-> (irq_sel_o == '0 && !irq_we_o));

  a_r6_select_onehot: assert property (@(posedge pclk_i) disable iff (!rst_ni)
    $onehot0(irq_sel_o));

  a_r6_we_needs_select: assert property (@(posedge pclk_i) disable iff (!rst_ni)
    irq_we_o |-> (pwrite_i && $countones(irq_sel_o) == 1));

  a_r2_pad_holds_without_write: assert property (@(posedge pclk_i) disable iff (!rst_ni)
    !(psel_i && penable_i && pwrite_i) |=> $stable(pad_o));

  a_r3_oe_holds_without_write: assert property (@(posedge pclk_i) disable iff (!rst_ni)
    !(psel_i && penable_i && pwrite_i) |=> $stable(pad_oe_o));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_w
    localparam logic [DATA_W-1:0] UPPER = ~port_mask(PORT_W[p]);
    a_r5_upper_bits_zero: assert property (@(posedge pclk_i) disable iff (!rst_ni)
      ((pad_o[p*DATA_W +: DATA_W] | pad_oe_o[p*DATA_W +: DATA_W]) & UPPER) == '0);
  end
endmodule

bind apb_gpio_bank apb_gpio_bank_chk #(
  .NUM_PORTS(NUM_PORTS),
  .PORT_W   (PORT_W)
) u_chk (
  .pclk_i   (pclk_i),
  .rst_ni   (rst_ni),
  .psel_i   (psel_i),
  .penable_i(penable_i),
  .pwrite_i (pwrite_i),
  .pready_o (pready_o),
  .pslverr_o(pslverr_o),
  .pad_o    (pad_o),
  .pad_oe_o (pad_oe_o),
  .irq_sel_o(irq_sel_o),
  .irq_we_o (irq_we_o)
);

// File: tb/apb_gpio_bank_test.sv
module apb_gpio_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 3;
  localparam int PW = NP * 32;
  localparam int unsigned WIDTHS [4] = '{32, 20, 8, 32};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] irq_rd = 32'hC0DE_0001;
  logic [PW-1:0] pad_in = '0;

  logic [31:0] prd_d, prd_a, iwd_d, iwd_a;
  logic rdy_d, rdy_a, err_d, err_a, iwe_d, iwe_a;
  logic [PW-1:0] po_d, po_a, poe_d, poe_a;
  logic [6:0] sel_d, sel_a;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  apb_gpio_bank #(.NUM_PORTS(NP), .PORT_W(WIDTHS), .ALT_MAP(1'b0)) uut (
    .pclk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prd_d),
    .pready_o(rdy_d), .pslverr_o(err_d), .pad_i(pad_in), .pad_o(po_d),
    .pad_oe_o(poe_d), .irq_sel_o(sel_d), .irq_we_o(iwe_d),
    .irq_wdata_o(iwd_d), .irq_rdata_i(irq_rd));

  apb_gpio_bank #(.NUM_PORTS(NP), .PORT_W(WIDTHS), .ALT_MAP(1'b1)) uut_alt (
    .pclk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prd_a),
    .pready_o(rdy_a), .pslverr_o(err_a), .pad_i(pad_in), .pad_o(po_a),
    .pad_oe_o(poe_a), .irq_sel_o(sel_a), .irq_we_o(iwe_a),
    .irq_wdata_o(iwd_a), .irq_rdata_i(irq_rd));

  // reference model state
  logic [31:0] m_dr [NP];
  logic [31:0] m_ddr [NP];
  logic [31:0] m_s1 [NP];
  logic [31:0] m_s2 [NP];
  int def_off [7] = '{'h30, 'h34, 'h38, 'h3C, 'h40, 'h48, 'h4C};
  int alt_off [7] = '{'h30, 'h44, 'h34, 'h38, 'h3C, 'h48, 'h40};

  function automatic logic [31:0] wmask(input int p);
    return (WIDTHS[p] >= 32) ? 32'hFFFF_FFFF : ((32'd1 << WIDTHS[p]) - 32'd1);
  endfunction

  function automatic logic [6:0] exp_sel(input logic [7:0] a, input bit alt);
    logic [6:0] s = '0;
    for (int r = 0; r < 7; r++)
      if (int'(a) == (alt ? alt_off[r] : def_off[r])) s[r] = 1'b1;
    return s;
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a, input bit alt);
    for (int p = 0; p < NP; p++) begin
      if (int'(a) == 12*p)        return m_dr[p];
      if (int'(a) == 12*p + 4)    return m_ddr[p];
      if (int'(a) == 'h50 + 4*p)  return m_s2[p];
    end
    if (exp_sel(a, alt) != '0) return irq_rd;
    return '0;
  endfunction

  function automatic string addr_req(input logic [7:0] a, input bit alt);
    if (alt && exp_sel(a, 1'b1) != '0) return "R7";
    for (int p = 0; p < NP; p++) begin
      if (int'(a) == 12*p)       return (WIDTHS[p] < 32) ? "R2/R5" : "R2";
      if (int'(a) == 12*p + 4)   return (WIDTHS[p] < 32) ? "R3/R5" : "R3";
      if (int'(a) == 'h50 + 4*p) return (WIDTHS[p] < 32) ? "R4/R5" : "R4";
    end
    if (exp_sel(a, 1'b0) != '0) return "R6";
    return "R8";
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  // model update: writes happen in the access phase only (R10)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int p = 0; p < NP; p++) begin
        m_dr[p] = '0; m_ddr[p] = '0; m_s1[p] = '0; m_s2[p] = '0;
      end
    end else begin
      for (int p = 0; p < NP; p++) begin
        if (psel && penable && pwrite) begin
          if (int'(paddr) == 12*p)     m_dr[p]  = pwdata & wmask(p);
          if (int'(paddr) == 12*p + 4) m_ddr[p] = pwdata & wmask(p);
        end
        m_s2[p] = m_s1[p];
        m_s1[p] = pad_in[p*32 +: 32] & wmask(p);
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      if (!rst_n) begin
        chk(po_d == '0 && poe_d == '0, "R1", po_d[31:0] | poe_d[31:0], 32'h0);
      end else begin
        for (int p = 0; p < NP; p++) begin
          chk(po_d[p*32 +: 32] == m_dr[p], "R2", po_d[p*32 +: 32], m_dr[p]);
          chk(poe_d[p*32 +: 32] == m_ddr[p], "R3", poe_d[p*32 +: 32], m_ddr[p]);
          chk(po_a[p*32 +: 32] == m_dr[p], "R7", po_a[p*32 +: 32], m_dr[p]);
        end
        chk(rdy_d && !err_d && rdy_a && !err_a, "R9", {30'd0, rdy_d, err_d}, 32'h2);
        if (psel && penable) begin
          chk(sel_d == exp_sel(paddr, 1'b0), "R6", 32'(sel_d), 32'(exp_sel(paddr, 1'b0)));
          chk(sel_a == exp_sel(paddr, 1'b1), "R7", 32'(sel_a), 32'(exp_sel(paddr, 1'b1)));
          chk(iwe_d == (pwrite && exp_sel(paddr, 1'b0) != '0), "R6", 32'(iwe_d), 32'(pwrite));
          chk(iwe_a == (pwrite && exp_sel(paddr, 1'b1) != '0), "R7", 32'(iwe_a), 32'(pwrite));
          if (pwrite) begin
            chk(iwd_d == pwdata, "R6", iwd_d, pwdata);
          end else begin
            chk(prd_d == exp_read(paddr, 1'b0), addr_req(paddr, 1'b0), prd_d, exp_read(paddr, 1'b0));
            chk(prd_a == exp_read(paddr, 1'b1), addr_req(paddr, 1'b1), prd_a, exp_read(paddr, 1'b1));
          end
        end else begin
          chk(sel_d == '0 && !iwe_d && sel_a == '0 && !iwe_a, "R10", 32'(sel_d), 32'h0);
        end
      end
    end
  end

  // pads toggle every cycle so the synchronizer depth is visible (R4)
  always @(negedge clk) begin
    #2;
    if (!done) pad_in <= {$urandom, $urandom, $urandom};
  end

  task automatic apb_xfer(input bit wr, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
    @(negedge clk); #1;
    penable = 1'b1;
    @(negedge clk); #1;
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic setup_only(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
    repeat (3) @(negedge clk);
    #1 psel = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    #1 rst_n = 1'b1;
    // R1: everything reads zero after reset
    for (int p = 0; p < NP; p++) begin
      apb_xfer(1'b0, 8'(12*p), 0);
      apb_xfer(1'b0, 8'(12*p + 4), 0);
    end
    // R2, R3, R5: all-ones and patterns per port, narrow ports masked
    for (int p = 0; p < NP; p++) begin
      apb_xfer(1'b1, 8'(12*p), 32'hFFFF_FFFF);
      apb_xfer(1'b0, 8'(12*p), 0);
      apb_xfer(1'b1, 8'(12*p + 4), 32'hFFFF_FFFF);
      apb_xfer(1'b0, 8'(12*p + 4), 0);
      apb_xfer(1'b1, 8'(12*p), 32'h5A3C_96E1 ^ 32'(p));
      apb_xfer(1'b1, 8'(12*p + 4), 32'h0F0F_F0F0);
      apb_xfer(1'b0, 8'(12*p), 0);
    end
    // R4: pin-level reads; writes there ignored
    for (int k = 0; k < 6; k++)
      for (int p = 0; p < NP; p++) begin
        apb_xfer(1'b1, 8'('h50 + 4*p), 32'hDEAD_BEEF);
        apb_xfer(1'b0, 8'('h50 + 4*p), 0);
      end
    // R6, R7: interrupt offsets in both layouts
    for (int r = 0; r < 7; r++) begin
      irq_rd = 32'hC0DE_0000 | 32'(r);
      apb_xfer(1'b0, 8'(def_off[r]), 0);
      apb_xfer(1'b0, 8'(alt_off[r]), 0);
      apb_xfer(1'b1, 8'(def_off[r]), 32'h1234_0000 | 32'(r));
      apb_xfer(1'b1, 8'(alt_off[r]), 32'h5678_0000 | 32'(r));
    end
    // R8: missing port 3, unaligned and unused offsets
    apb_xfer(1'b1, 8'h24, 32'hFFFF_FFFF);
    apb_xfer(1'b1, 8'h28, 32'hFFFF_FFFF);
    apb_xfer(1'b0, 8'h24, 0);
    apb_xfer(1'b0, 8'h28, 0);
    apb_xfer(1'b0, 8'h5C, 0);
    apb_xfer(1'b1, 8'h01, 32'hFFFF_FFFF);
    apb_xfer(1'b0, 8'h01, 0);
    apb_xfer(1'b0, 8'h31, 0);
    apb_xfer(1'b0, 8'h2C, 0);
    apb_xfer(1'b0, 8'hFC, 0);
    // R10: setup phase alone never writes
    setup_only(8'h00, 32'h0000_0000);
    setup_only(8'h10, 32'h0000_0000);
    setup_only(8'h30, 32'h0000_0000);
    apb_xfer(1'b0, 8'h00, 0);
    apb_xfer(1'b0, 8'h10, 0);
    // sweep every offset in both directions
    for (int a = 0; a < 'h64; a++) begin
      apb_xfer(1'b1, 8'(a), $urandom);
      apb_xfer(1'b0, 8'(a), 0);
    end
    // random mix
    for (int k = 0; k < 300; k++) begin
      irq_rd = $urandom;
      apb_xfer(1'($urandom_range(0, 1)), 8'($urandom_range(0, 'h63)), $urandom);
    end
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule